// File: doc/BRIEF.md
# Linear CCD Sensor Timing Generator

This block drives a linear CCD image sensor that has its own clock drivers. It generates three pulses from one fast system clock: the pixel clock, a readout-gate pulse that begins every line, and an electronic-shutter pulse whose position in the line sets the integration time. Each pixel period is split into eight phase ticks, and one phase tick lasts a programmable number of system clocks. The gate and shutter edges therefore land exactly a quarter period away from the pixel-clock edges. For capture logic downstream, the block gives a one-cycle line-start strobe and a one-cycle per-pixel valid strobe.

Software writes three values together through a single write strobe: the divider, the line length and the shutter pixel position. An out-of-range divider or line length is discarded. All three values wait in pending registers and take effect only when a line starts. A shutter position that would come within the minimum spacing of the readout gate is pulled forward to the earliest legal pixel when it is too early, or dropped for the line when it is too late. Either case sets a sticky error flag. A synchronous enable starts the generator at a line boundary. Dropping the enable lets the current line finish before the generator stops.

Top module: `ccd_line_timing`

## Requirements
- R1: During and after a synchronous reset with the enable low, every pulse output and the error flag are 0. The active settings are divider DIV_DEF, length MIN_LINE and shutter pixel ROG_W+GAP.
- R2: While running, the pixel clock has a period of 8*div system clocks. It is high for the first 4*div clocks of each pixel and low for the remaining 4*div.
- R3: A divider write outside [DIV_MIN, DIV_MAX] is discarded. A legal divider takes effect only at the next line start.
- R4: A line lasts len pixel periods, measured from one line start to the next. A length write outside [MIN_LINE, MAX_LINE] is discarded. A legal length takes effect only at the next line start.
- R5: The readout gate rises 2*div system clocks after the pixel clock rises at pixel 0. It stays high for exactly ROG_W pixel periods, so both of its edges fall a quarter period from a pixel-clock edge.
- R6: For a shutter pixel S, the shutter rises at S*8*div + 2*div system clocks after line start and stays high for SHUT_W pixel periods. It never overlaps the gate, and at least GAP pixel periods separate it from the gate on each side.
- R7: A shutter pixel below ROG_W+GAP is replaced by ROG_W+GAP for the line, and the error flag is set.
- R8: A shutter pixel above len-GAP-SHUT_W produces no shutter pulse for that line, and the error flag is set. Once set, the error flag stays 1 until reset.
- R9: When enable is sampled high while the generator is idle, the next cycle is the first cycle of a line, with line_start high. When enable is sampled low, the current line runs to its end and the pixel clock then stays low.
- R10: line_start is high for exactly one system clock, the first clock of each line. pix_valid is high for one clock, the last high clock of the pixel clock, for pixels OUT_OFS through OUT_OFS+OUT_LEN-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable, sampled every clock |
| cfg_we | input | 1 | Write strobe for the three pending settings |
| cfg_div | input | DIV_W | System clocks per phase tick (eighth of a pixel) |
| cfg_len | input | LEN_W | Pixel periods per line |
| cfg_shut | input | LEN_W | Requested shutter pixel within the line |
| pclk_o | output | 1 | Pixel clock to the sensor |
| rog_o | output | 1 | Readout-gate pulse to the sensor |
| shut_o | output | 1 | Electronic-shutter pulse to the sensor |
| line_start | output | 1 | First-cycle-of-line strobe |
| pix_valid | output | 1 | Per-pixel capture strobe |
| shut_err | output | 1 | Sticky flag: shutter request was clamped or dropped |

## Verification
The assertions check four things on every cycle. First, gate and shutter edges only occur while the pixel clock is high and steady. Second, the gate and shutter widths match the active divider. Third, the two pulses never overlap. Fourth, the generator stops only at a line end, and the error flag never clears by itself. The bench's scenarios are needed to show the behaviours that depend on history: rejected writes that leave the timing unchanged, settings that wait for the next line boundary, a shutter clamped to an exact offset, a shutter dropped for a whole line, and a disable that finishes the line in progress.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;
  // A pixel period is split into eight phase ticks.
  localparam int PHASES  = 8;
  localparam int QUARTER = 2;
  localparam int HALF    = 4;

  function automatic logic in_range(input int unsigned v, input int unsigned lo,
                                    input int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // pos counts phase ticks from line start; the window opens a quarter
  // period into pixel 'start' and lasts 'width' whole pixel periods.
  function automatic logic win_hit(input int unsigned pos, input int unsigned start,
                                   input int unsigned width);
    return (pos >= start * PHASES + QUARTER) &&
           (pos < (start + width) * PHASES + QUARTER);
  endfunction
endpackage

// File: rtl/ccd_phase_div.sv
module ccd_phase_div #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic             sub0,
  output logic [2:0]       ph
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div - 1'b1);
  assign sub0 = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      ph  <= '0;
    end else if (tick) begin
      cnt <= '0;
      ph  <= ph + 3'd1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ccd_line_ctrl.sv
module ccd_line_ctrl
  import ccd_tg_pkg::*;
#(
  parameter int DIV_W    = 7,
  parameter int LEN_W    = 13,
  parameter int DIV_MIN  = 13,
  parameter int DIV_MAX  = 125,
  parameter int DIV_DEF  = 50,
  parameter int MIN_LINE = 3100,
  parameter int MAX_LINE = 8191,
  parameter int ROG_W    = 10,
  parameter int SHUT_W   = 5,
  parameter int GAP      = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [LEN_W-1:0] cfg_shut,
  input  logic             tick,
  input  logic [2:0]       ph,
  output logic             run_q,
  output logic             line_end,
  output logic [LEN_W-1:0] pix,
  output logic [DIV_W-1:0] act_div,
  output logic [LEN_W-1:0] shut_pos,
  output logic             shut_on,
  output logic             shut_err
);
  localparam int SHUT_LO = ROG_W + GAP;

  logic [DIV_W-1:0] pend_div;
  logic [LEN_W-1:0] pend_len, pend_shut, act_len;
  logic             load;
  logic [LEN_W-1:0] place_pos;
  logic             place_on, place_bad;
  int               shut_hi;

  assign line_end = run_q && tick && (ph == 3'd7) && (pix == act_len - 1'b1);
  assign load     = en && (!run_q || line_end);

  // Shutter placement for the line about to start, from the pending values.
  always_comb begin
    shut_hi   = int'(pend_len) - GAP - SHUT_W;
    place_pos = pend_shut;
    place_on  = 1'b1;
    place_bad = 1'b0;
    if (int'(pend_shut) < SHUT_LO) begin
      place_pos = LEN_W'(SHUT_LO);
      place_bad = 1'b1;
    end else if (int'(pend_shut) > shut_hi) begin
      place_on  = 1'b0;
      place_bad = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_div  <= DIV_W'(DIV_DEF);
      pend_len  <= LEN_W'(MIN_LINE);
      pend_shut <= LEN_W'(SHUT_LO);
      act_div   <= DIV_W'(DIV_DEF);
      act_len   <= LEN_W'(MIN_LINE);
      shut_pos  <= LEN_W'(SHUT_LO);
      shut_on   <= 1'b1;
      shut_err  <= 1'b0;
      run_q     <= 1'b0;
      pix       <= '0;
    end else begin
      if (cfg_we) begin
        if (in_range(32'(cfg_div), DIV_MIN, DIV_MAX)) pend_div <= cfg_div;
        if (in_range(32'(cfg_len), MIN_LINE, MAX_LINE)) pend_len <= cfg_len;
        pend_shut <= cfg_shut;
      end
      if (load) begin
        act_div  <= pend_div;
        act_len  <= pend_len;
        shut_pos <= place_pos;
        shut_on  <= place_on;
        if (place_bad) shut_err <= 1'b1;
        run_q    <= 1'b1;
        pix      <= '0;
      end else if (line_end) begin
        run_q <= 1'b0;
        pix   <= '0;
      end else if (run_q && tick && (ph == 3'd7)) begin
        pix <= pix + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ccd_pulse_dec.sv
module ccd_pulse_dec
  import ccd_tg_pkg::*;
#(
  parameter int LEN_W   = 13,
  parameter int ROG_W   = 10,
  parameter int SHUT_W  = 5,
  parameter int OUT_OFS = 1,
  parameter int OUT_LEN = 3066
) (
  input  logic             run,
  input  logic             tick,
  input  logic             sub0,
  input  logic [2:0]       ph,
  input  logic [LEN_W-1:0] pix,
  input  logic [LEN_W-1:0] shut_pos,
  input  logic             shut_on,
  output logic             pclk_o,
  output logic             rog_o,
  output logic             shut_o,
  output logic             line_start,
  output logic             pix_valid
);
  localparam int NWIN = 2;   // window 0: readout gate, window 1: shutter

  logic [LEN_W+2:0]  pos;
  logic [NWIN-1:0]   win_act;
  int unsigned       win_start [NWIN];
  int unsigned       win_width [NWIN];
  logic [NWIN-1:0]   win_en;

  assign pos = {pix, ph};

  always_comb begin
    win_start[0] = 0;
    win_width[0] = ROG_W;
    win_en[0]    = 1'b1;
    win_start[1] = 32'(shut_pos);
    win_width[1] = SHUT_W;
    win_en[1]    = shut_on;
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign win_act[w] = run && win_en[w] &&
                        win_hit(32'(pos), win_start[w], win_width[w]);
  end

  assign pclk_o     = run && (32'(ph) < HALF);
  assign rog_o      = win_act[0];
  assign shut_o     = win_act[1];
  assign line_start = run && sub0 && (ph == 3'd0) && (pix == '0);
  assign pix_valid  = tick && (32'(ph) == HALF - 1) &&
                      (32'(pix) >= OUT_OFS) && (32'(pix) < OUT_OFS + OUT_LEN);
endmodule

// File: rtl/ccd_line_timing.sv
module ccd_line_timing #(
  parameter int DIV_MIN  = 13,
  parameter int DIV_MAX  = 125,
  parameter int DIV_DEF  = 50,
  parameter int MIN_LINE = 3100,
  parameter int MAX_LINE = 8191,
  parameter int ROG_W    = 10,
  parameter int SHUT_W   = 5,
  parameter int GAP      = 10,
  parameter int OUT_OFS  = 1,
  parameter int OUT_LEN  = 3066,
  localparam int DIV_W   = $clog2(DIV_MAX + 1),
  localparam int LEN_W   = $clog2(MAX_LINE + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [LEN_W-1:0] cfg_shut,
  output logic             pclk_o,
  output logic             rog_o,
  output logic             shut_o,
  output logic             line_start,
  output logic             pix_valid,
  output logic             shut_err
);
  // Internal events, named for the bound checker.
  logic             run_q, line_end, tick, sub0, shut_on;
  logic [2:0]       ph;
  logic [LEN_W-1:0] pix, shut_pos;
  logic [DIV_W-1:0] act_div;

  ccd_phase_div #(.DIV_W(DIV_W)) u_phase (
    .clk(clk), .rst(rst), .run(run_q), .div(act_div),
    .tick(tick), .sub0(sub0), .ph(ph)
  );

  ccd_line_ctrl #(
    .DIV_W(DIV_W), .LEN_W(LEN_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX),
    .DIV_DEF(DIV_DEF), .MIN_LINE(MIN_LINE), .MAX_LINE(MAX_LINE),
    .ROG_W(ROG_W), .SHUT_W(SHUT_W), .GAP(GAP)
  ) u_ctrl (
    .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we), .cfg_div(cfg_div),
    .cfg_len(cfg_len), .cfg_shut(cfg_shut), .tick(tick), .ph(ph),
    .run_q(run_q), .line_end(line_end), .pix(pix), .act_div(act_div),
    .shut_pos(shut_pos), .shut_on(shut_on), .shut_err(shut_err)
  );

  ccd_pulse_dec #(
    .LEN_W(LEN_W), .ROG_W(ROG_W), .SHUT_W(SHUT_W),
    .OUT_OFS(OUT_OFS), .OUT_LEN(OUT_LEN)
  ) u_dec (
    .run(run_q), .tick(tick), .sub0(sub0), .ph(ph), .pix(pix),
    .shut_pos(shut_pos), .shut_on(shut_on), .pclk_o(pclk_o), .rog_o(rog_o),
    .shut_o(shut_o), .line_start(line_start), .pix_valid(pix_valid)
  );
endmodule

// File: rtl/ccd_line_timing_chk.sv
module ccd_line_timing_chk #(
  parameter int ROG_W  = 10,
  parameter int SHUT_W = 5,
  parameter int DIV_W  = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             pclk_o,
  input logic             rog_o,
  input logic             shut_o,
  input logic             line_start,
  input logic             pix_valid,
  input logic             shut_err,
  input logic             run_q,
  input logic             line_end,
  input logic [DIV_W-1:0] act_div
);
  logic [31:0] rog_cnt, shut_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rog_cnt  <= '0;
      shut_cnt <= '0;
    end else begin
      rog_cnt  <= rog_o  ? rog_cnt + 32'd1  : 32'd0;
      shut_cnt <= shut_o ? shut_cnt + 32'd1 : 32'd0;
    end
  end

  assert_rog_edge_phase_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(rog_o) || $fell(rog_o)) |-> (pclk_o && $stable(pclk_o)));

  assert_rog_width_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(rog_o) |-> (rog_cnt == 32'(ROG_W * 8) * 32'(act_div)));

  assert_shut_edge_phase_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(shut_o) || $fell(shut_o)) |-> (pclk_o && $stable(pclk_o)));

  assert_shut_width_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(shut_o) |-> (shut_cnt == 32'(SHUT_W * 8) * 32'(act_div)));

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
    !(rog_o && shut_o));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    shut_err |=> shut_err);

  assert_stop_at_end_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> $past(line_end));

  assert_strobe_order_R10: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> !pclk_o);

  assert_start_clock_R10: assert property (@(posedge clk) disable iff (rst)
    line_start |-> (pclk_o && !rog_o && !pix_valid));
endmodule

bind ccd_line_timing ccd_line_timing_chk #(
  .ROG_W(ROG_W), .SHUT_W(SHUT_W), .DIV_W(DIV_W)
) u_chk (
  .clk(clk), .rst(rst), .pclk_o(pclk_o), .rog_o(rog_o), .shut_o(shut_o),
  .line_start(line_start), .pix_valid(pix_valid), .shut_err(shut_err),
  .run_q(run_q), .line_end(line_end), .act_div(act_div)
);

// File: tb/tb_ccd_line_timing.sv
`timescale 1ns/1ps
module tb_ccd_line_timing;
  localparam int DMIN = 1, DMAX = 4, DDEF = 2, LMIN = 40, LMAX = 63;
  localparam int RW = 10, SW = 5, GP = 10, OFS = 1, OL = 20;
  localparam int LO = RW + GP;

  logic clk = 0, rst = 1, en = 0, cfg_we = 0;
  logic [2:0] cfg_div = 0;
  logic [5:0] cfg_len = 0, cfg_shut = 0;
  logic pclk_o, rog_o, shut_o, line_start, pix_valid, shut_err;

  ccd_line_timing #(.DIV_MIN(DMIN), .DIV_MAX(DMAX), .DIV_DEF(DDEF),
    .MIN_LINE(LMIN), .MAX_LINE(LMAX), .ROG_W(RW), .SHUT_W(SW), .GAP(GP),
    .OUT_OFS(OFS), .OUT_LEN(OL)) dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      if (fails < 20) $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ---- behavioural reference model: time-in-line counter ----
  int m_run, m_t, m_div, m_len, m_s, m_son, m_err, p_div, p_len, p_shut, ld;
  bit started = 0;
  always @(posedge clk) begin
    cyc++;
    started = 1;
    if (rst) begin
      m_run = 0; m_t = 0; p_div = DDEF; p_len = LMIN; p_shut = LO;
      m_div = DDEF; m_len = LMIN; m_s = LO; m_son = 1; m_err = 0;
    end else begin
      ld = 0;
      if (m_run != 0) begin
        if (m_t == m_len * 8 * m_div - 1) begin
          if (en) ld = 1; else m_run = 0;
          m_t = 0;
        end else m_t++;
      end else if (en) begin
        ld = 1; m_run = 1; m_t = 0;
      end
      if (ld != 0) begin
        m_div = p_div; m_len = p_len;
        if (p_shut < LO) begin m_s = LO; m_son = 1; m_err = 1; end
        else if (p_shut > p_len - GP - SW) begin m_son = 0; m_err = 1; end
        else begin m_s = p_shut; m_son = 1; end
      end
      if (cfg_we) begin
        if (cfg_div >= DMIN && cfg_div <= DMAX) p_div = int'(cfg_div);
        if (cfg_len >= LMIN && cfg_len <= LMAX) p_len = int'(cfg_len);
        p_shut = int'(cfg_shut);
      end
    end
  end

  // ---- per-cycle compare and edge monitor ----
  int t_prise = 0, hi_len = 0, t_ls = 0, line_per = 0, rog_off = 0, t_rogf = 0;
  int shut_gap = 0, shut_off = 0, ls_count = 0;
  bit shut_seen = 0, pp = 0, pr = 0, ps = 0;
  always @(negedge clk) begin
    if (started) begin
      int per, q, pt, px;
      bit e_p, e_r, e_s, e_l, e_v;
      per = 8 * m_div; q = 2 * m_div; pt = m_t % per; px = m_t / per;
      e_p = (m_run != 0) && pt < 4 * m_div;
      e_r = (m_run != 0) && m_t >= q && m_t < q + RW * per;
      e_s = (m_run != 0) && (m_son != 0) && m_t >= m_s * per + q && m_t < (m_s + SW) * per + q;
      e_l = (m_run != 0) && m_t == 0;
      e_v = (m_run != 0) && pt == 4 * m_div - 1 && px >= OFS && px < OFS + OL;
      chk(pclk_o == e_p, "R2 pclk", pclk_o, e_p);
      chk(rog_o == e_r, "R5 rog", rog_o, e_r);
      chk(shut_o == e_s, "R6 shutter", shut_o, e_s);
      chk(line_start == e_l, "R10 line_start", line_start, e_l);
      chk(pix_valid == e_v, "R10 pix_valid", pix_valid, e_v);
      chk(shut_err == (m_err != 0), "R8 shut_err", shut_err, m_err);
    end
    if (pclk_o && !pp) t_prise = cyc;
    if (!pclk_o && pp) hi_len = cyc - t_prise;
    if (line_start) begin line_per = cyc - t_ls; t_ls = cyc; ls_count++; end
    if (rog_o && !pr) rog_off = cyc - t_prise;
    if (!rog_o && pr) t_rogf = cyc;
    if (shut_o && !ps) begin shut_gap = cyc - t_rogf; shut_off = cyc - t_ls; end
    if (shut_o) shut_seen = 1;
    pp = pclk_o; pr = rog_o; ps = shut_o;
  end

  always @(posedge clk) if (cyc > 100000) begin
    fails++; checks++;
    $display("FAIL watchdog R1..all actual=%0d expected<100000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic write_cfg(input int d, input int l, input int s);
    @(negedge clk);
    cfg_div = 3'(d); cfg_len = 6'(l); cfg_shut = 6'(s); cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    int drop, ls0;
    wait_cyc(3);
    // R1: reset state
    chk(!pclk_o && !rog_o && !shut_o && !line_start && !pix_valid, "R1 outputs", pclk_o, 0);
    chk(!shut_err, "R1 err", shut_err, 0);
    rst = 0;
    wait_cyc(2);
    chk(!pclk_o && !line_start, "R1 idle after reset", pclk_o, 0);

    write_cfg(2, 40, 22);
    en = 1;
    wait_cyc(1400);
    chk(line_per == 640, "R4 line period", line_per, 640);
    chk(rog_off == 4, "R5 gate quarter offset", rog_off, 4);
    chk(shut_gap >= GP * 16, "R6 gate-shutter gap", shut_gap, GP * 16);
    chk(shut_off == 356, "R6 shutter position", shut_off, 356);
    chk(hi_len == 8, "R2 pclk high time", hi_len, 8);

    write_cfg(5, 30, 22);   // both out of range: discarded
    wait_cyc(700);
    chk(hi_len == 8, "R3 bad divider ignored", hi_len, 8);
    chk(line_per == 640, "R4 bad length ignored", line_per, 640);

    write_cfg(3, 48, 22);   // legal, mid-line
    wait_cyc(2600);
    chk(hi_len == 12, "R3 new divider", hi_len, 12);
    chk(line_per == 1152, "R4 new length", line_per, 1152);
    chk(rog_off == 6, "R5 gate offset div3", rog_off, 6);

    write_cfg(3, 48, 5);    // too early: clamped to LO
    wait_cyc(2400);
    chk(shut_off == LO * 24 + 6, "R7 clamped shutter", shut_off, LO * 24 + 6);
    chk(shut_err, "R7 error flag", shut_err, 1);

    // R8: late shutter dropped, flag sticky
    en = 0; rst = 1; wait_cyc(3); rst = 0;
    chk(!shut_err, "R1 err cleared by reset", shut_err, 0);
    write_cfg(2, 40, 30);
    shut_seen = 0;
    en = 1;
    wait_cyc(700);
    chk(!shut_seen, "R8 shutter dropped", shut_seen, 0);
    chk(shut_err, "R8 error flag", shut_err, 1);
    write_cfg(2, 40, 22);
    shut_seen = 0;
    wait_cyc(1300);
    chk(shut_seen, "R8 shutter back", shut_seen, 1);
    chk(shut_err, "R8 error sticky", shut_err, 1);

    // R9: disable finishes the line
    while (!line_start) @(negedge clk);
    wait_cyc(100);
    en = 0; drop = cyc;
    wait_cyc(800);
    chk(t_prise >= drop + 400, "R9 line finished", t_prise - drop, 400);
    chk(!pclk_o && !rog_o, "R9 stopped low", pclk_o, 0);
    ls0 = ls_count;
    wait_cyc(50);
    chk(ls_count == ls0, "R9 no restart", ls_count, ls0);
    en = 1;
    @(negedge clk);
    chk(line_start, "R9 start strobe", line_start, 1);
    wait_cyc(700);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule